// File: doc/BRIEF.md
# Shared-Memory Mailbox Add Sequencer

This block is a control sequencer that carries one kind of command from a host processor to the fabric, through a word-addressed on-chip RAM that both sides share. The host writes two 32-bit operands and then raises a command flag. The sequencer polls the flag word. When the flag reads exactly one, it fetches both operands and forms their 32-bit wrap-around sum. It stores the sum in a small private scratch RAM, reads it back, and publishes it at a fixed result word of the shared RAM. It then writes zero over the flag to hand the mailbox back to the host.

The sequencer drives a synchronous single-port master interface towards the shared RAM: an address, a write enable, a byte-lane mask, write data and read data. That RAM has a registered read, so every read is spread over three states. In the first the address is presented, in the second the sequencer waits, and in the third the data is captured. The scratch RAM is instantiated inside the block as a simple dual-port memory with a registered read output and follows the same read discipline.

Word map of the shared RAM: word 0 is the flag, words 1 and 2 hold the operands, and word 3 receives the result.

Top module: `mbox_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `sh_we` is 0, `done` is 0 and `sh_addr` is 0.
- R2: If the flag word (address 0) holds any value other than exactly 1, the sequencer makes no writes and raises no `done`. The result word and the flag word keep the values the host wrote. Values 0, 2, 3, 0x101, 0x80000001 and 0xFFFFFFFF do not start a command.
- R3: A read address is held on `sh_addr` for at least two consecutive cycles. Data is sampled only after the RAM's one-cycle registered latency, so each captured operand belongs to the address that was presented.
- R4: When the flag reads 1, the word written to address 3 is (word1 + word2) mod 2^32.
- R5: The sum is written into the scratch RAM and read back after its registered read latency. The value written to address 3 is the value read back from the scratch RAM.
- R6: Each command ends with a write to address 3, followed in the very next cycle by a write of 0 to address 0. The flag is never cleared before the result has been written.
- R7: `done` is high for exactly one cycle per command, in the cycle where the flag-clearing write (address 0, data 0, `sh_we`=1) is driven.
- R8: Each command makes exactly two one-cycle writes: one to address 3 and one of the value 0 to address 0. No write goes to any other address.
- R9: `sh_be` is 4'b1111 in every cycle, so every write updates all four byte lanes.
- R10: A synchronous reset during a command abandons it and returns the sequencer to polling with `sh_we` low. If the flag is still 1 when reset is released, the command is executed again from the start and completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequencer, the scratch RAM and the shared RAM port |
| rst | input | 1 | Synchronous active-high reset |
| sh_addr | output | ADDR_W (8) | Word address presented to the shared RAM |
| sh_we | output | 1 | Shared RAM write enable, one cycle per write |
| sh_be | output | 4 | Byte-lane mask for writes, always all ones |
| sh_wdata | output | 32 | Shared RAM write data |
| sh_rdata | input | 32 | Shared RAM registered read data |
| done | output | 1 | One-cycle pulse when the flag is cleared |

## Verification
The hardest situation to reach from the ports is a reset that lands in the middle of a command while the flag is still 1. The block must drop its partly fetched operands, leave the result and flag words alone, and then run the whole command again from the start. The bench reaches this state by raising the flag and counting a few cycles into the operand fetch before it pulses reset. A second hard case is a flag value that differs from 1 in only a single bit, or in a high bit. The bench sweeps a set of such near-miss values and checks that neither word of the mailbox is touched. The bench shared-RAM model returns the data of the previous address when a read is captured too early, so any shortened read timing shows up as a wrong sum.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int DATA_W    = 32;
  localparam int BE_W      = DATA_W / 8;
  localparam int FLAG_WORD = 0;
  localparam int OPA_WORD  = 1;
  localparam int OPB_WORD  = 2;
  localparam int RES_WORD  = 3;
  localparam logic [DATA_W-1:0] GO_VALUE = DATA_W'(1);

  typedef logic [DATA_W-1:0] word_t;

  // Sequencer states. Each shared-RAM read occupies an issue edge, a wait
  // state (_W) and a capture state (_C).
  typedef enum logic [3:0] {
    ST_SETTLE, // one idle cycle after the flag clear so the next poll sees it
    ST_POLL_W,
    ST_POLL_C,
    ST_OPA_W,
    ST_OPA_C,
    ST_OPB_W,
    ST_OPB_C,
    ST_SC_RA,  // scratch write lands, scratch read address issued
    ST_SC_RW,
    ST_SC_RC,
    ST_CLEAR
  } seq_state_e;

  // Wrap-around combine of the two operands.
  function automatic word_t mbox_combine(input word_t a, input word_t b);
    return a + b;
  endfunction

  // The command starts only on an exact match with the go value.
  function automatic logic mbox_is_go(input word_t flag);
    return flag == GO_VALUE;
  endfunction

endpackage

// File: rtl/mbox_scratch_ram.sv
module mbox_scratch_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] store [DEPTH];

  // Write port.
  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  // Registered read port. A read in the same cycle as a write to the same
  // slot returns the old contents.
  always_ff @(posedge clk) begin
    rdata <= store[raddr];
  end

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SC_AW   = 2,
  parameter int SC_SLOT = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] sh_addr_o,
  output logic              sh_we_o,
  output word_t             sh_wdata_o,
  input  word_t             sh_rdata_i,
  output logic              sc_we_o,
  output logic [SC_AW-1:0]  sc_waddr_o,
  output word_t             sc_wdata_o,
  output logic [SC_AW-1:0]  sc_raddr_o,
  input  word_t             sc_rdata_i,
  output logic              done_o
);

  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_WORD);
  localparam logic [ADDR_W-1:0] A_OPA  = ADDR_W'(OPA_WORD);
  localparam logic [ADDR_W-1:0] A_OPB  = ADDR_W'(OPB_WORD);
  localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(RES_WORD);
  localparam logic [SC_AW-1:0]  S_SLOT = SC_AW'(SC_SLOT);

  seq_state_e state_q;
  word_t      op_a_q;
  word_t      sum_q;

  // Named internal events.
  logic flag_hit;    // flag captured and equal to the go value
  logic flag_miss;   // flag captured with any other value
  logic sc_capture;  // scratch read data is sampled
  logic clr_issue;   // flag-clear write is being set up

  assign flag_hit   = (state_q == ST_POLL_C) &&  mbox_is_go(sh_rdata_i);
  assign flag_miss  = (state_q == ST_POLL_C) && !mbox_is_go(sh_rdata_i);
  assign sc_capture = (state_q == ST_SC_RC);
  assign clr_issue  = (state_q == ST_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_SETTLE;
      sh_addr_o  <= A_FLAG;
      sh_we_o    <= 1'b0;
      sh_wdata_o <= '0;
      sc_we_o    <= 1'b0;
      sc_waddr_o <= '0;
      sc_wdata_o <= '0;
      sc_raddr_o <= '0;
      done_o     <= 1'b0;
      op_a_q     <= '0;
      sum_q      <= '0;
    end else begin
      sh_we_o <= 1'b0;
      sc_we_o <= 1'b0;
      done_o  <= 1'b0;
      unique case (state_q)
        ST_SETTLE: begin
          sh_addr_o <= A_FLAG;
          state_q   <= ST_POLL_W;
        end
        ST_POLL_W: state_q <= ST_POLL_C;
        ST_POLL_C: begin
          if (flag_hit) begin
            sh_addr_o <= A_OPA;
            state_q   <= ST_OPA_W;
          end else if (flag_miss) begin
            state_q   <= ST_POLL_W;
          end
        end
        ST_OPA_W: state_q <= ST_OPA_C;
        ST_OPA_C: begin
          op_a_q    <= sh_rdata_i;
          sh_addr_o <= A_OPB;
          state_q   <= ST_OPB_W;
        end
        ST_OPB_W: state_q <= ST_OPB_C;
        ST_OPB_C: begin
          sum_q      <= mbox_combine(op_a_q, sh_rdata_i);
          sc_we_o    <= 1'b1;
          sc_waddr_o <= S_SLOT;
          sc_wdata_o <= mbox_combine(op_a_q, sh_rdata_i);
          state_q    <= ST_SC_RA;
        end
        ST_SC_RA: begin
          sc_raddr_o <= S_SLOT;
          state_q    <= ST_SC_RW;
        end
        ST_SC_RW: state_q <= ST_SC_RC;
        ST_SC_RC: begin
          sh_addr_o  <= A_RES;
          sh_wdata_o <= sc_rdata_i;
          sh_we_o    <= 1'b1;
          state_q    <= ST_CLEAR;
        end
        ST_CLEAR: begin
          sh_addr_o  <= A_FLAG;
          sh_wdata_o <= '0;
          sh_we_o    <= 1'b1;
          done_o     <= 1'b1;
          state_q    <= ST_SETTLE;
        end
        default: state_q <= ST_SETTLE;
      endcase
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!sh_we_o && !done_o && sh_addr_o == A_FLAG)); // R1

  AST_READ_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sh_we_o && sh_addr_o != $past(sh_addr_o)) |=> $stable(sh_addr_o)); // R3

  AST_SCRATCH_READBACK: assert property (@(posedge clk) disable iff (rst)
    sc_capture |-> (sc_rdata_i == sum_q)); // R5

  AST_CLEAR_FOLLOWS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (sh_we_o && sh_addr_o == A_RES) |=> (sh_we_o && sh_addr_o == A_FLAG && sh_wdata_o == '0)); // R6

  AST_DONE_WITH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (sh_we_o && sh_addr_o == A_FLAG && sh_wdata_o == '0)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7

  AST_WRITE_TARGETS: assert property (@(posedge clk) disable iff (rst)
    sh_we_o |-> (sh_addr_o == A_RES || (sh_addr_o == A_FLAG && sh_wdata_o == '0))); // R8

  AST_CLEAR_ONLY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    clr_issue |=> done_o); // R7

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SC_DEPTH = 4,
  parameter int SC_SLOT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] sh_addr,
  output logic              sh_we,
  output logic [3:0]        sh_be,
  output logic [31:0]       sh_wdata,
  input  logic [31:0]       sh_rdata,
  output logic              done
);

  localparam int SC_AW = (SC_DEPTH > 1) ? $clog2(SC_DEPTH) : 1;

  logic             sc_we;
  logic [SC_AW-1:0] sc_waddr;
  logic [SC_AW-1:0] sc_raddr;
  word_t            sc_wdata;
  word_t            sc_rdata;

  assign sh_be = {BE_W{1'b1}};

  mbox_ctrl #(
    .ADDR_W (ADDR_W),
    .SC_AW  (SC_AW),
    .SC_SLOT(SC_SLOT)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .sh_addr_o (sh_addr),
    .sh_we_o   (sh_we),
    .sh_wdata_o(sh_wdata),
    .sh_rdata_i(sh_rdata),
    .sc_we_o   (sc_we),
    .sc_waddr_o(sc_waddr),
    .sc_wdata_o(sc_wdata),
    .sc_raddr_o(sc_raddr),
    .sc_rdata_i(sc_rdata),
    .done_o    (done)
  );

  mbox_scratch_ram #(
    .DW   (DATA_W),
    .DEPTH(SC_DEPTH)
  ) scratch_i (
    .clk  (clk),
    .we   (sc_we),
    .waddr(sc_waddr),
    .wdata(sc_wdata),
    .raddr(sc_raddr),
    .rdata(sc_rdata)
  );

endmodule

// File: tb/mbox_seq_tb.sv
module mbox_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  sh_addr;
  logic        sh_we;
  logic [3:0]  sh_be;
  logic [31:0] sh_wdata;
  logic [31:0] sh_rdata;
  logic        done;

  logic        h_we = 1'b0;
  logic [7:0]  h_addr = '0;
  logic [31:0] h_data = '0;

  logic [31:0] shm [256];

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  int done_cnt = 0;
  int bad_be = 0, bad_done = 0, bad_order = 0, bad_target = 0, bad_hold = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_seq dut_i (
    .clk(clk), .rst(rst), .sh_addr(sh_addr), .sh_we(sh_we), .sh_be(sh_be),
    .sh_wdata(sh_wdata), .sh_rdata(sh_rdata), .done(done)
  );

  // Shared RAM model: registered read, design port wins a write collision.
  initial begin
    for (int i = 0; i < 256; i++) shm[i] = '0;
  end
  always @(posedge clk) begin
    if (sh_we) shm[sh_addr] <= sh_wdata;
    else if (h_we) shm[h_addr] <= h_data;
    sh_rdata <= shm[sh_addr];
  end

  // Port monitor.
  logic       prev_res_wr = 1'b0;
  logic       prev_done = 1'b0;
  logic       hold_due = 1'b0;
  logic [7:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst) begin
      prev_res_wr = 1'b0; prev_done = 1'b0; hold_due = 1'b0; prev_addr = sh_addr;
    end else begin
      if (sh_be !== 4'hF) bad_be++;                                      // R9
      if (sh_we) wr_cnt++;
      if (done) done_cnt++;
      if (done && !(sh_we && sh_addr == 8'd0 && sh_wdata == 0)) bad_done++; // R7
      if (done && prev_done) bad_done++;                                 // R7
      if (prev_res_wr && !(sh_we && sh_addr == 8'd0)) bad_order++;       // R6
      if (sh_we && sh_addr == 8'd0 && !prev_res_wr) bad_order++;         // R6
      if (sh_we && !(sh_addr == 8'd3 || (sh_addr == 8'd0 && sh_wdata == 0))) bad_target++; // R8
      if (hold_due && sh_addr != prev_addr) bad_hold++;                  // R3
      hold_due    = !sh_we && (sh_addr != prev_addr);
      prev_res_wr = sh_we && sh_addr == 8'd3;
      prev_done   = done;
      prev_addr   = sh_addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    h_we = 1'b1; h_addr = a; h_data = d;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    int t = 0;
    while (done_cnt == d0 && t < 200) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [31:0] a, input logic [31:0] b, input logic [31:0] sent);
    logic [32:0] wide;
    int d0, w0;
    wide = {1'b0, a} + {1'b0, b};
    host_wr(8'd1, a);
    host_wr(8'd2, b);
    host_wr(8'd3, sent);
    d0 = done_cnt; w0 = wr_cnt;
    host_wr(8'd0, 32'd1);
    wait_done(d0);
    chk(done_cnt == d0 + 1, "R7 one done per command", done_cnt - d0, 1);
    chk(shm[3] == wide[31:0], "R4 R5 result word", shm[3], wide[31:0]);
    chk(shm[0] == 0, "R6 flag cleared", shm[0], 0);
    chk(wr_cnt - w0 == 2, "R8 two writes per command", wr_cnt - w0, 2);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] bad_flags [6];
    bad_flags = '{32'd0, 32'd2, 32'd3, 32'h101, 32'h8000_0001, 32'hFFFF_FFFF};

    repeat (3) @(negedge clk);
    chk(sh_we == 0 && done == 0 && sh_addr == 0, "R1 reset outputs", {sh_we, done, sh_addr}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sh_we == 0 && done == 0 && sh_addr == 0, "R1 first cycle after reset", {sh_we, done, sh_addr}, 0);
    repeat (10) @(negedge clk);
    chk(wr_cnt == 0, "R2 idle with flag 0", wr_cnt, 0);

    // R4 corner operands (carry into bit 32 is dropped)
    run_cmd(32'd0, 32'd0, 32'hA5A5_0001);
    run_cmd(32'hFFFF_FFFF, 32'd1, 32'hA5A5_0002);
    run_cmd(32'h8000_0000, 32'h8000_0000, 32'hA5A5_0003);
    run_cmd(32'h7FFF_FFFF, 32'd1, 32'hA5A5_0004);
    run_cmd(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hA5A5_0005);

    // R4 sweep of operand patterns
    for (int i = 0; i < 16; i++) begin
      run_cmd(i * 32'h1111_1111, ~(32'(i) << 28) ^ 32'(i * 7), 32'hB000_0000 | 32'(i));
    end

    // R2 near-miss flag values start nothing
    foreach (bad_flags[k]) begin
      int d0, w0;
      host_wr(8'd3, 32'hC0DE_0000 | 32'(k));
      d0 = done_cnt; w0 = wr_cnt;
      host_wr(8'd0, bad_flags[k]);
      repeat (30) @(negedge clk);
      chk(wr_cnt == w0 && done_cnt == d0, "R2 no write or done", wr_cnt - w0, 0);
      chk(shm[3] == (32'hC0DE_0000 | 32'(k)), "R2 result untouched", shm[3], 32'hC0DE_0000 | 32'(k));
      chk(shm[0] == bad_flags[k], "R2 flag untouched", shm[0], bad_flags[k]);
      host_wr(8'd0, 32'd0);
    end

    // R10 reset in the middle of the operand fetch
    begin
      int d0;
      host_wr(8'd1, 32'h1234_5678);
      host_wr(8'd2, 32'h1111_1111);
      host_wr(8'd3, 32'hDEAD_0000);
      d0 = done_cnt;
      host_wr(8'd0, 32'd1);
      repeat (4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(sh_we == 0 && done == 0, "R10 reset mid-command quiet", {sh_we, done}, 0);
      @(negedge clk);
      chk(shm[3] == 32'hDEAD_0000, "R10 no result before restart", shm[3], 32'hDEAD_0000);
      rst = 1'b0;
      wait_done(d0);
      chk(done_cnt == d0 + 1, "R10 command rerun once", done_cnt - d0, 1);
      chk(shm[3] == 32'h2345_6789, "R10 rerun result", shm[3], 32'h2345_6789);
      chk(shm[0] == 0, "R10 flag cleared after rerun", shm[0], 0);
    end

    chk(bad_be == 0, "R9 byte mask all ones", bad_be, 0);
    chk(bad_done == 0, "R7 done shape", bad_done, 0);
    chk(bad_order == 0, "R6 clear follows result", bad_order, 0);
    chk(bad_target == 0, "R8 write targets", bad_target, 0);
    chk(bad_hold == 0, "R3 read address held", bad_hold, 0);

    summary();
    $finish;
  end

endmodule